// File: doc/BRIEF.md
# Cache-Line Burst Bridge

This block connects the line-refill and line-eviction paths of a processor's two caches to the system memory bus. Each request names a line address, a direction (fill or write-back) and the originating cache. The block turns the request into a run of single-word bus transfers. A data-cache line is four 32-bit words and an instruction-cache line is eight. Fill words are streamed back to the cache with their index. Write-back words are taken from a line image captured when the request is accepted.

Only the low cacheable RAM window may be the target of a line transfer. A request whose line base lies above that window causes no bus activity at all. Instead it latches a freeze flag that holds the core stall output high until the next reset. Inside the window, the block sends words in the RAM range and the register range at the top of the window to the bus. Words in the unmapped hole between those ranges are skipped, and they return zero on a fill. Each burst occupies the block for a fixed number of core cycles that depends on the originating cache. A done pulse marks the last of those cycles.

Top module: `line_burst_bridge`

## Requirements
- R1: A burst from the data cache (`req_icache`=0) moves exactly 4 words, and a burst from the instruction cache (`req_icache`=1) moves exactly 8 words, each 32 bits wide.
- R2: The line base is the request address with its low offset bits cleared: 4 bits for the data cache and 5 bits for the instruction cache. Word k of the burst uses address base+4k, in strictly ascending k, and the first word is always at the line base.
- R3: A burst is performed only when the line base is at or below 0x03FF_FFFF, for reads and writes alike. A base of 0x0400_0000 or higher produces no bus transfer, no fill word and no done pulse, and it sets the freeze flag.
- R4: Once set, the freeze flag keeps `core_stall` high until reset. Every later request is ignored while it is set.
- R5: Word addresses at or below 0x007F_FFFF and in 0x03F0_0000..0x03FF_FFFF are issued on the bus. Word addresses in 0x0080_0000..0x03EF_FFFF are not issued, and their fill word reads as zero.
- R6: The burst occupies the block for 80 cycles (data cache) or 96 cycles (instruction cache), counted from the accepting clock edge. `busy` is high throughout that span, and `done` pulses for one cycle in its last cycle.
- R7: A request presented while `busy` is high is ignored and causes no extra transfer.
- R8: On a write-back (`req_write`=1), word k drives `mem_wdata` with bits [32k+31:32k] of `req_line` as captured at acceptance, with `mem_write` high and no fill output. On a fill, the fill word for index k is the bus read data.
- R9: After reset, `busy`, `done`, `core_stall`, `mem_valid` and `fill_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset, the only way to clear a freeze |
| req_valid | input | 1 | Burst request strobe |
| req_write | input | 1 | 1 = write-back, 0 = fill |
| req_icache | input | 1 | 1 = instruction-cache line, 0 = data-cache line |
| req_addr | input | 32 | Line address (offset bits ignored) |
| req_line | input | 256 | Line image for a write-back, word k at bits [32k+31:32k] |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse in the final cycle of a completed burst |
| core_stall | output | 1 | Freeze flag; core must neither fetch nor retire |
| fill_valid | output | 1 | A fill word is presented this cycle |
| fill_idx | output | 3 | Word index of the fill word |
| fill_word | output | 32 | Fill word data |
| mem_valid | output | 1 | Single-word bus transfer this cycle |
| mem_write | output | 1 | Bus transfer direction |
| mem_addr | output | 32 | Bus word address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, same cycle as `mem_valid` |

## Verification
The hardest situation to reach from the ports is a request arriving while the block is already busy or frozen. In either state the request must leave no trace. The stimulus pulses a second, differently addressed request in the middle of a running burst. It then drives a fresh in-window request after an out-of-window one has locked the block. The scoreboard treats any bus or fill activity it did not predict as a failure, so both cases are checked. The window edge is approached from both sides, with a line base of 0x03FF_FFF0 (request 0x03FF_FFFC) and with 0x0400_0000, and the unmapped hole is exercised to show skipped words returning zero.

// File: rtl/line_burst_bridge.sv
module line_burst_bridge #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int DC_WORDS  = 4,
  parameter int IC_WORDS  = 8,
  parameter int DC_CYCLES = 80,
  parameter int IC_CYCLES = 96,
  parameter logic [ADDR_W-1:0] WINDOW_TOP = 32'h03FF_FFFF,
  parameter logic [ADDR_W-1:0] RAM_TOP    = 32'h007F_FFFF,
  parameter logic [ADDR_W-1:0] HOLE_TOP   = 32'h03EF_FFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_icache,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [IC_WORDS*WORD_W-1:0] req_line,
  output logic                       busy,
  output logic                       done,
  output logic                       core_stall,
  output logic                       fill_valid,
  output logic [$clog2(IC_WORDS)-1:0] fill_idx,
  output logic [WORD_W-1:0]          fill_word,
  output logic                       mem_valid,
  output logic                       mem_write,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [WORD_W-1:0]          mem_wdata,
  input  logic [WORD_W-1:0]          mem_rdata
);
  localparam int LINE_W  = IC_WORDS * WORD_W;
  localparam int IDX_W   = $clog2(IC_WORDS);
  localparam int MAX_CYC = (IC_CYCLES > DC_CYCLES) ? IC_CYCLES : DC_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BYTE_SH = $clog2(WORD_W / 8);
  localparam logic [ADDR_W-1:0] DC_OFS = ADDR_W'(DC_WORDS * WORD_W / 8 - 1);
  localparam logic [ADDR_W-1:0] IC_OFS = ADDR_W'(IC_WORDS * WORD_W / 8 - 1);

  logic              busy_q, frozen_q, wr_q, ic_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [LINE_W-1:0] line_q;

  logic [ADDR_W-1:0] req_base, cur_addr;
  logic [CNT_W-1:0]  n_words, n_cycles;
  logic              accept, in_window, xfer, mapped, last_cyc;
  logic [IDX_W-1:0]  widx;

  assign req_base  = req_addr & ~(req_icache ? IC_OFS : DC_OFS);
  assign accept    = req_valid && !busy_q && !frozen_q;
  assign in_window = req_base <= WINDOW_TOP;

  assign n_words  = ic_q ? CNT_W'(IC_WORDS)  : CNT_W'(DC_WORDS);
  assign n_cycles = ic_q ? CNT_W'(IC_CYCLES) : CNT_W'(DC_CYCLES);
  assign last_cyc = busy_q && (cnt_q == n_cycles - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      frozen_q <= 1'b0;
      wr_q     <= 1'b0;
      ic_q     <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      line_q   <= '0;
    end else if (accept) begin
      if (in_window) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        base_q <= req_base;
        wr_q   <= req_write;
        ic_q   <= req_icache;
        line_q <= req_line;
      end else begin
        frozen_q <= 1'b1;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last_cyc) busy_q <= 1'b0;
    end
  end

  assign widx     = cnt_q[IDX_W-1:0];
  assign xfer     = busy_q && (cnt_q < n_words);
  assign cur_addr = base_q + (ADDR_W'(cnt_q) << BYTE_SH);
  assign mapped   = (cur_addr <= RAM_TOP) || (cur_addr > HOLE_TOP);

  assign mem_valid  = xfer && mapped;
  assign mem_write  = wr_q;
  assign mem_addr   = cur_addr;
  assign mem_wdata  = line_q[widx*WORD_W +: WORD_W];
  assign fill_valid = xfer && !wr_q;
  assign fill_idx   = widx;
  assign fill_word  = mapped ? mem_rdata : '0;
  assign busy       = busy_q;
  assign done       = last_cyc;
  assign core_stall = frozen_q;

  assert_freeze_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> core_stall);
  assert_frozen_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> !(mem_valid || fill_valid || done || busy));
  assert_bus_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr <= WINDOW_TOP);
  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $past(xfer)) |-> cur_addr == $past(cur_addr) + ADDR_W'(WORD_W / 8));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_hole_skipped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !mem_valid) |-> fill_word == '0);
  assert_fill_not_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> !fill_valid);
endmodule

// File: tb/line_burst_bridge_bench.sv
`timescale 1ns/1ps
module line_burst_bridge_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_icache = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [255:0] req_line = '0;
  logic         busy, done, core_stall, fill_valid, mem_valid, mem_write;
  logic [2:0]   fill_idx;
  logic [31:0]  fill_word, mem_addr, mem_wdata, mem_rdata;

  int total = 0, bad = 0, done_cnt = 0;
  bit finished = 0;

  logic [31:0] qa[$], qd[$];
  logic        qw[$];
  int          fi[$];
  logic [31:0] fd[$];

  always #4 clk = ~clk;

  assign mem_rdata = {mem_addr[15:0], ~mem_addr[15:0]};

  line_burst_bridge u_line_burst_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_icache(req_icache), .req_addr(req_addr), .req_line(req_line),
    .busy(busy), .done(done), .core_stall(core_stall), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .fill_word(fill_word), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic bit on_bus(input logic [31:0] a);
    return (a <= 32'h007F_FFFF) || (a >= 32'h03F0_0000);
  endfunction

  always @(negedge clk) if (rst_n && !finished) begin
    if (mem_valid) begin
      if (qa.size() == 0) chk(0, "R3/R7 unexpected bus transfer", {32'h0, mem_addr}, 64'h0);
      else begin
        logic [31:0] ea, ed; logic ew;
        ea = qa.pop_front(); ed = qd.pop_front(); ew = qw.pop_front();
        chk(mem_addr == ea, "R2 word address order", {32'h0, mem_addr}, {32'h0, ea});
        chk(mem_write == ew, "R8 bus direction", {63'h0, mem_write}, {63'h0, ew});
        if (ew) chk(mem_wdata == ed, "R8 write-back data", {32'h0, mem_wdata}, {32'h0, ed});
      end
    end
    if (fill_valid) begin
      if (fi.size() == 0) chk(0, "R1/R8 unexpected fill word", {61'h0, fill_idx}, 64'h0);
      else begin
        int ei; logic [31:0] ed;
        ei = fi.pop_front(); ed = fd.pop_front();
        chk(int'(fill_idx) == ei, "R1 fill index", {61'h0, fill_idx}, 64'(ei));
        chk(fill_word == ed, "R5/R8 fill data", {32'h0, fill_word}, {32'h0, ed});
      end
    end
    if (done) done_cnt++;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic burst(input bit wr, input bit ic, input logic [31:0] addr,
                       input logic [255:0] line, input bit poke);
    logic [31:0] base;
    int nw, cost, n;
    nw   = ic ? 8 : 4;
    cost = ic ? 96 : 80;
    base = addr & (ic ? 32'hFFFF_FFE0 : 32'hFFFF_FFF0);
    for (int k = 0; k < nw; k++) begin
      logic [31:0] a;
      a = base + 32'(4 * k);
      if (on_bus(a)) begin
        qa.push_back(a); qw.push_back(wr); qd.push_back(line[32*k +: 32]);
      end
      if (!wr) begin
        fi.push_back(k); fd.push_back(on_bus(a) ? rd_model(a) : 32'h0);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_icache = ic; req_addr = addr; req_line = line;
    @(negedge clk);
    req_valid = 1'b0; req_line = ~line;
    n = 1;
    while (!done && n < 200) begin
      if (poke && n == 5) begin
        req_valid = 1'b1; req_write = 1'b0; req_icache = 1'b1; req_addr = 32'h0000_2000;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (n < cost) chk(busy == 1'b1, "R6 busy held", {63'h0, busy}, 64'h1);
    end
    chk(n == cost, "R6 burst length in cycles", 64'(n), 64'(cost));
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R6 idle after done", {62'h0, busy, done}, 64'h0);
    chk(qa.size() == 0 && fi.size() == 0, "R1 all words transferred", 64'(qa.size() + fi.size()), 64'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic freeze_case(input bit wr, input bit ic, input logic [31:0] addr);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_icache = ic; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(core_stall == 1'b1, "R3 freeze set", {63'h0, core_stall}, 64'h1);
    chk(busy == 1'b0, "R3 no burst started", {63'h0, busy}, 64'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_icache = 1'b0; req_addr = 32'h0000_0100;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (120) @(negedge clk);
    chk(core_stall == 1'b1, "R4 freeze sticky", {63'h0, core_stall}, 64'h1);
    chk(busy == 1'b0, "R4 request ignored when frozen", {63'h0, busy}, 64'h0);
    chk(done_cnt == d0, "R3 no done on frozen burst", 64'(done_cnt), 64'(d0));
    do_reset();
    @(negedge clk);
    chk(core_stall == 1'b0, "R4 reset clears freeze", {63'h0, core_stall}, 64'h0);
  endtask

  initial begin
    logic [255:0] pat;
    do_reset();
    @(negedge clk);
    chk({busy, done, core_stall, mem_valid, fill_valid} == 5'b0, "R9 reset state",
        {59'h0, busy, done, core_stall, mem_valid, fill_valid}, 64'h0);
    burst(0, 0, 32'h0000_1234, '0, 0);
    burst(0, 1, 32'h0010_0048, '0, 0);
    for (int k = 0; k < 8; k++) pat[32*k +: 32] = 32'hC0DE_0000 + 32'(k * 17);
    burst(1, 0, 32'h0020_0008, pat, 0);
    burst(1, 1, 32'h03F0_0000, pat, 0);
    burst(0, 0, 32'h0100_0000, '0, 0);
    burst(0, 1, 32'h007F_FFF0, '0, 0);
    burst(0, 0, 32'h03FF_FFFC, '0, 0);
    burst(0, 0, 32'h0000_4000, '0, 1);
    freeze_case(0, 0, 32'h0400_0000);
    freeze_case(1, 1, 32'h0400_0000);
    freeze_case(0, 1, 32'hFFFF_FFE0);
    burst(1, 0, 32'h0000_0040, pat, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R6 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule